// File: doc/BRIEF.md
# Dual-Module Mode-Switchable Data Cache

This block is the first-level data cache of a two-cluster machine, split into two 8 KB modules, one per cluster. Each module has one read/write port and runs in one of three modes chosen by software: a fast mode with a short hit latency, a slow low-energy mode with a longer hit latency, or off. The two modes trade energy per access against latency. The configuration is changed only at a software-chosen point such as a context switch, by presenting new modes and pulsing an apply strobe.

The top address bit splits the address space into a fast data region, served by module 0, and a slow data region, served by module 1. When the module that owns a region is off, requests for that region go to the other module if it is running. If both modules are off, requests pass straight through to the next memory level, which has one port per module. Stores are written through to the next level. Two 32-bit counters record how many accesses were served in each mode, for energy estimation.

Top module: `hetero_dcache`

## Requirements
- R1: An address with bit 31 clear is served by module 0 and its next-level traffic uses port 0. An address with bit 31 set is served by module 1 and uses port 1, as long as the owning module is not off.
- R2: Mode code 2'b01 is fast. In that mode a read hit returns data 2 clock edges after the accepting edge. A read miss issues a line request on the next-level port and returns data one edge after the next-level acknowledge.
- R3: Mode code 2'b10 is slow. In that mode a read hit returns data 4 edges after the accepting edge, and a read miss takes one edge more than the hit time when the next level acknowledges at once.
- R4: A store is always sent to the next level with its address and data, and the port holds the request until it is acknowledged. A store that hits also updates the cached word. Its response comes one edge after the acknowledge.
- R5: Codes 2'b00 and 2'b11 mean off. A request whose owning module is off is served by the other module if that module is on. If both modules are off, the request goes uncached to the next-level port of its own region and is answered one edge after the acknowledge.
- R6: A module that goes from on to off loses all its cached lines. A module that changes between fast and slow keeps them.
- R7: An apply pulse captures the new modes. The new modes take effect once no access is in flight, and a 2-cycle stall follows. Both ready outputs stay low from the apply edge until the stall has ended, so with idle modules ready is low for the three cycles after the pulse.
- R8: Each cluster has at most one access outstanding. When both clusters target the same module in one cycle, cluster 0 is accepted and cluster 1 is held.
- R9: Each accepted access increments the fast counter if its serving module is in fast mode, and the slow counter if it is in slow mode. Uncached pass-through accesses change neither counter.
- R10: After reset, both modules are in fast mode with no valid lines, both counters read zero, no response is pending, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_apply | input | 1 | Pulse that requests a mode change |
| cfg_mode | input | 2x2 | New mode per module (element n for module n) |
| cl_valid | input | 2 | Access request per cluster |
| cl_ready | output | 2 | Request accepted on this edge when high together with valid |
| cl_we | input | 2 | Store when high, load when low |
| cl_addr | input | 2x32 | Byte address per cluster |
| cl_wdata | input | 2x32 | Store data per cluster |
| cl_rvalid | output | 2 | One-cycle response strobe per cluster |
| cl_rdata | output | 2x32 | Load data per cluster (zero for stores) |
| nl_req | output | 2 | Next-level request per port, held until acknowledged |
| nl_we | output | 2 | Next-level store when high |
| nl_addr | output | 2x32 | Next-level address |
| nl_wdata | output | 2x32 | Next-level store data |
| nl_ack | input | 2 | Next-level acknowledge |
| nl_rline | input | 2x128 | Line returned with the acknowledge (word k in bits 32k+31:32k) |
| fast_cnt | output | 32 | Accesses served in fast mode |
| slow_cnt | output | 32 | Accesses served in slow mode |

## Verification
The bench counts latency in rising edges from the edge that accepts a request and reads the responses at the falling edge in between. In these terms a read hit is due at edge 2 in fast mode and edge 4 in slow mode. A miss or a store is due one edge later than the hit time, and an uncached pass-through is due at edge 1, because the bench's next-level model acknowledges in the cycle the request appears. After an apply pulse with idle modules, ready is read low at three consecutive falling edges and high at the fourth. Next-level port use is counted per port to show steering, hits and redirection. Invalidation is shown by a load that returns the next level's value with miss latency, rather than the stored word with hit latency.

// File: rtl/hetero_dcache_pkg.sv
// Package: shared mode codes and helpers for the dual-module cache.
// Assumes two-bit mode fields; any code other than fast or slow means off.
package hetero_dcache_pkg;
    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_FAST = 2'b01;
    localparam logic [1:0] MODE_SLOW = 2'b10;

    // True when the mode code keeps the module running.
    function automatic logic mode_on(input logic [1:0] m);
        return (m == MODE_FAST) || (m == MODE_SLOW);
    endfunction
endpackage

// File: rtl/hetero_dcache_bank.sv
// Module: one direct-mapped cache module with a single blocking port.
// Hit latency depends on the mode sampled at acceptance. Loads miss to a
// line fill, stores are write-through without allocation, and in off mode
// every access passes uncached to the next level. Assumes the mode changes
// only while the module is idle.
module hetero_dcache_bank
    import hetero_dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 512,
    parameter int FAST_LAT   = 2,
    parameter int SLOW_LAT   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode,
    input  logic                          inval,
    input  logic                          start,
    input  logic                          start_we,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic [DATA_W-1:0]             start_wdata,
    input  logic                          start_cl,
    output logic                          busy,
    output logic                          resp_valid,
    output logic                          resp_cl,
    output logic [DATA_W-1:0]             resp_rdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic                          mem_ack,
    input  logic [LINE_BYTES*8-1:0]       mem_rline
);
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int CNT_W  = $clog2(SLOW_LAT + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MEM} st_e;

    st_e                          st_q;
    logic [CNT_W-1:0]             cnt_q;
    logic                         we_q, byp_q, cl_q;
    logic [ADDR_W-1:0]            addr_q;
    logic [DATA_W-1:0]            wdata_q;
    logic [DATA_W-1:0]            rdata_q;
    logic                         rvalid_q;
    logic                         req_q;
    logic [NUM_LINES-1:0]         valid_q;
    logic [TAG_W-1:0]             tag_mem  [NUM_LINES];
    logic [WORDS-1:0][DATA_W-1:0] line_mem [NUM_LINES];

    logic [IDX_W-1:0]             idx;
    logic [TAG_W-1:0]             tag;
    logic [OFF_W-BOFF_W-1:0]      wsel;
    logic [WORDS-1:0][DATA_W-1:0] cur_line;
    logic [WORDS-1:0][DATA_W-1:0] fill_line;
    logic                         hit, fill, wr_hit, look_done;

    // Address split and lookup of the stored line.
    always_comb begin
        idx       = addr_q[OFF_W+IDX_W-1:OFF_W];
        tag       = addr_q[ADDR_W-1:OFF_W+IDX_W];
        wsel      = addr_q[OFF_W-1:BOFF_W];
        cur_line  = line_mem[idx];
        fill_line = mem_rline;
        hit       = valid_q[idx] && (tag_mem[idx] == tag);
        look_done = (st_q == ST_LOOK) && (cnt_q == '0);
        fill      = (st_q == ST_MEM) && mem_ack && !we_q && !byp_q;
        wr_hit    = look_done && we_q && hit;
    end

    // Line storage: fill on a miss return, word update on a store hit.
    always_ff @(posedge clk) begin
        if (fill) begin
            line_mem[idx] <= fill_line;
            tag_mem[idx]  <= tag;
        end else if (wr_hit) begin
            line_mem[idx][wsel] <= wdata_q;
        end
    end

    // Access sequencer: latency countdown, lookup, next-level handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            we_q     <= 1'b0;
            byp_q    <= 1'b0;
            cl_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            req_q    <= 1'b0;
            valid_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            if (inval) begin
                valid_q <= '0;
            end
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        we_q    <= start_we;
                        wdata_q <= start_wdata;
                        cl_q    <= start_cl;
                        if (!mode_on(mode)) begin
                            byp_q <= 1'b1;
                            req_q <= 1'b1;
                            st_q  <= ST_MEM;
                        end else begin
                            byp_q <= 1'b0;
                            st_q  <= ST_LOOK;
                            cnt_q <= (mode == MODE_FAST) ? CNT_W'(FAST_LAT - 1)
                                                         : CNT_W'(SLOW_LAT - 1);
                        end
                    end
                end
                ST_LOOK: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (hit && !we_q) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= cur_line[wsel];
                        st_q     <= ST_IDLE;
                    end else begin
                        req_q <= 1'b1;
                        st_q  <= ST_MEM;
                    end
                end
                default: begin
                    if (mem_ack) begin
                        req_q    <= 1'b0;
                        rvalid_q <= 1'b1;
                        rdata_q  <= we_q ? '0 : fill_line[wsel];
                        if (!we_q && !byp_q) begin
                            valid_q[idx] <= 1'b1;
                        end
                        st_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign resp_valid = rvalid_q;
    assign resp_cl    = cl_q;
    assign resp_rdata = rdata_q;
    assign mem_req    = req_q;
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
endmodule

// File: rtl/hetero_dcache_cfg.sv
// Module: mode register with deferred commit and a fixed post-change stall.
// An apply pulse captures new modes. They commit once both modules are idle,
// and then hold stays high for STALL_CYC cycles. Modules leaving service
// receive a one-cycle invalidate at the commit.
module hetero_dcache_cfg
    import hetero_dcache_pkg::*;
#(
    parameter int NUM_MODS  = 2,
    parameter int STALL_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply,
    input  logic [NUM_MODS-1:0][1:0] new_mode,
    input  logic                     idle,
    output logic [NUM_MODS-1:0][1:0] mode,
    output logic                     hold,
    output logic [NUM_MODS-1:0]      inval
);
    localparam int ST_W = $clog2(STALL_CYC + 1);

    logic [NUM_MODS-1:0][1:0] mode_q, nxt_q;
    logic                     pend_q;
    logic [ST_W-1:0]          stall_q;
    logic                     commit;

    assign commit = pend_q && idle;

    // Pending capture, commit and stall countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_MODS; n++) begin
                mode_q[n] <= MODE_FAST;
            end
            nxt_q   <= '0;
            pend_q  <= 1'b0;
            stall_q <= '0;
        end else if (commit) begin
            mode_q  <= nxt_q;
            pend_q  <= 1'b0;
            stall_q <= ST_W'(STALL_CYC);
        end else begin
            if (stall_q != '0) begin
                stall_q <= stall_q - ST_W'(1);
            end
            if (apply && !pend_q) begin
                pend_q <= 1'b1;
                nxt_q  <= new_mode;
            end
        end
    end

    // Invalidate strobe per module turning from on to off.
    for (genvar n = 0; n < NUM_MODS; n++) begin : g_inval
        assign inval[n] = commit && mode_on(mode_q[n]) && !mode_on(nxt_q[n]);
    end

    assign mode = mode_q;
    assign hold = pend_q || (stall_q != '0);
endmodule

// File: rtl/hetero_dcache_route.sv
// Module: steering and acceptance for two clusters onto two modules.
// The space bit picks the owning module, with a fallback to the other module
// when the owner is off and the other is on. Cluster 0 wins a shared target.
// Assumes exactly two clusters and two modules.
module hetero_dcache_route
    import hetero_dcache_pkg::*;
(
    input  logic [1:0]      valid,
    input  logic [1:0]      space,
    input  logic [1:0][1:0] mode,
    input  logic [1:0]      busy,
    input  logic [1:0]      outst,
    input  logic            hold,
    output logic [1:0]      sel,
    output logic [1:0]      ready,
    output logic [1:0]      grant,
    output logic [1:0]      start,
    output logic [1:0]      start_cl
);
    // Target selection with redirect around an off module.
    always_comb begin
        for (int c = 0; c < 2; c++) begin
            sel[c] = space[c];
            if (!mode_on(mode[space[c]]) && mode_on(mode[~space[c]])) begin
                sel[c] = ~space[c];
            end
        end
    end

    // Acceptance with fixed priority for cluster 0.
    always_comb begin
        ready[0] = !hold && !outst[0] && !busy[sel[0]];
        grant[0] = valid[0] && ready[0];
        ready[1] = !hold && !outst[1] && !busy[sel[1]] &&
                   !(grant[0] && (sel[0] == sel[1]));
        grant[1] = valid[1] && ready[1];
    end

    // Per-module start strobe and originating cluster.
    always_comb begin
        for (int e = 0; e < 2; e++) begin
            start[e]    = (grant[0] && (sel[0] == e[0])) ||
                          (grant[1] && (sel[1] == e[0]));
            start_cl[e] = !(grant[0] && (sel[0] == e[0]));
        end
    end
endmodule

// File: rtl/hetero_dcache.sv
// Module: top of the two-module mode-switchable data cache.
// Wires the configuration register, the steering logic and one cache module
// per cluster, routes responses back to clusters, and keeps per-mode access
// counters. Assumes the next level answers each port in request order.
module hetero_dcache
    import hetero_dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 512,
    parameter int FAST_LAT   = 2,
    parameter int SLOW_LAT   = 4,
    parameter int STALL_CYC  = 2,
    parameter int CNT_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_apply,
    input  logic [1:0][1:0]              cfg_mode,
    input  logic [1:0]                   cl_valid,
    output logic [1:0]                   cl_ready,
    input  logic [1:0]                   cl_we,
    input  logic [1:0][ADDR_W-1:0]       cl_addr,
    input  logic [1:0][DATA_W-1:0]       cl_wdata,
    output logic [1:0]                   cl_rvalid,
    output logic [1:0][DATA_W-1:0]       cl_rdata,
    output logic [1:0]                   nl_req,
    output logic [1:0]                   nl_we,
    output logic [1:0][ADDR_W-1:0]       nl_addr,
    output logic [1:0][DATA_W-1:0]       nl_wdata,
    input  logic [1:0]                   nl_ack,
    input  logic [1:0][LINE_BYTES*8-1:0] nl_rline,
    output logic [CNT_W-1:0]             fast_cnt,
    output logic [CNT_W-1:0]             slow_cnt
);
    localparam int SPACE_BIT = ADDR_W - 1;

    logic [1:0][1:0]        mode_w;
    logic                   hold_w;
    logic [1:0]             inval_w;
    logic [1:0]             sel_w, grant_w, start_w, start_cl_w;
    logic [1:0]             busy_w, resp_v_w, resp_cl_w;
    logic [1:0][DATA_W-1:0] resp_rd_w;
    logic [1:0]             outst_q;
    logic [1:0]             space_w;
    logic [CNT_W-1:0]       fast_q, slow_q, fast_inc, slow_inc;

    hetero_dcache_cfg #(.NUM_MODS(2), .STALL_CYC(STALL_CYC)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (cfg_apply),
        .new_mode (cfg_mode),
        .idle     (~|busy_w),
        .mode     (mode_w),
        .hold     (hold_w),
        .inval    (inval_w)
    );

    assign space_w = {cl_addr[1][SPACE_BIT], cl_addr[0][SPACE_BIT]};

    hetero_dcache_route i_route (
        .valid    (cl_valid),
        .space    (space_w),
        .mode     (mode_w),
        .busy     (busy_w),
        .outst    (outst_q),
        .hold     (hold_w),
        .sel      (sel_w),
        .ready    (cl_ready),
        .grant    (grant_w),
        .start    (start_w),
        .start_cl (start_cl_w)
    );

    for (genvar e = 0; e < 2; e++) begin : g_bank
        hetero_dcache_bank #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .LINE_BYTES (LINE_BYTES),
            .NUM_LINES  (NUM_LINES),
            .FAST_LAT   (FAST_LAT),
            .SLOW_LAT   (SLOW_LAT)
        ) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode        (mode_w[e]),
            .inval       (inval_w[e]),
            .start       (start_w[e]),
            .start_we    (cl_we[start_cl_w[e]]),
            .start_addr  (cl_addr[start_cl_w[e]]),
            .start_wdata (cl_wdata[start_cl_w[e]]),
            .start_cl    (start_cl_w[e]),
            .busy        (busy_w[e]),
            .resp_valid  (resp_v_w[e]),
            .resp_cl     (resp_cl_w[e]),
            .resp_rdata  (resp_rd_w[e]),
            .mem_req     (nl_req[e]),
            .mem_we      (nl_we[e]),
            .mem_addr    (nl_addr[e]),
            .mem_wdata   (nl_wdata[e]),
            .mem_ack     (nl_ack[e]),
            .mem_rline   (nl_rline[e])
        );
    end

    // Response return to the cluster that issued the access.
    always_comb begin
        cl_rvalid = '0;
        cl_rdata  = '0;
        for (int c = 0; c < 2; c++) begin
            for (int e = 0; e < 2; e++) begin
                if (resp_v_w[e] && (resp_cl_w[e] == c[0])) begin
                    cl_rvalid[c] = 1'b1;
                    cl_rdata[c]  = resp_rd_w[e];
                end
            end
        end
    end

    // One outstanding access per cluster.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (grant_w[c]) begin
                    outst_q[c] <= 1'b1;
                end else if (cl_rvalid[c]) begin
                    outst_q[c] <= 1'b0;
                end
            end
        end
    end

    // Counter increments from the modes of the modules that start an access.
    always_comb begin
        fast_inc = '0;
        slow_inc = '0;
        for (int e = 0; e < 2; e++) begin
            if (start_w[e] && (mode_w[e] == MODE_FAST)) begin
                fast_inc = fast_inc + CNT_W'(1);
            end
            if (start_w[e] && (mode_w[e] == MODE_SLOW)) begin
                slow_inc = slow_inc + CNT_W'(1);
            end
        end
    end

    // Per-mode access counters for energy estimation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= '0;
            slow_q <= '0;
        end else begin
            fast_q <= fast_q + fast_inc;
            slow_q <= slow_q + slow_inc;
        end
    end

    assign fast_cnt = fast_q;
    assign slow_cnt = slow_q;
endmodule

// File: rtl/hetero_dcache_chk.sv
// Module: property checker for the dual-module cache, attached by bind.
// Observes cluster handshakes, the next-level ports, the counters and the
// internal hold, steering and outstanding state.
module hetero_dcache_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             cl_valid,
    input logic [1:0]             cl_ready,
    input logic [1:0]             cl_rvalid,
    input logic                   hold,
    input logic [1:0]             outst,
    input logic [1:0]             sel,
    input logic [1:0]             nl_req,
    input logic [1:0]             nl_ack,
    input logic [1:0][ADDR_W-1:0] nl_addr,
    input logic [CNT_W-1:0]       fast_cnt,
    input logic [CNT_W-1:0]       slow_cnt
);
    // R7: nothing is accepted while a mode change is pending or stalling.
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ((cl_valid & cl_ready) == 2'b00));

    // R8: when both clusters target one module, cluster 1 waits.
    p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_valid[0] && cl_ready[0] && cl_valid[1] && (sel[0] == sel[1]))
        |-> !cl_ready[1]);

    // R9: counters advance by at most one per module each cycle.
    p_fast_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fast_cnt - $past(fast_cnt)) <= CNT_W'(2)));
    p_slow_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((slow_cnt - $past(slow_cnt)) <= CNT_W'(2)));

    for (genvar c = 0; c < 2; c++) begin : g_cl
        // R8: an accepted cluster is not ready again in the next cycle.
        p_single_outst_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cl_valid[c] && cl_ready[c]) |=> !cl_ready[c]);
        // R8: a response only reaches a cluster with an access in flight.
        p_rvalid_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cl_rvalid[c] |-> outst[c]);
    end

    for (genvar e = 0; e < 2; e++) begin : g_nl
        // R4: a next-level request holds with a stable address until acknowledged.
        p_nl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (nl_req[e] && !nl_ack[e]) |=> (nl_req[e] && $stable(nl_addr[e])));
    end
endmodule

bind hetero_dcache hetero_dcache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_hetero_dcache_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cl_valid  (cl_valid),
    .cl_ready  (cl_ready),
    .cl_rvalid (cl_rvalid),
    .hold      (hold_w),
    .outst     (outst_q),
    .sel       (sel_w),
    .nl_req    (nl_req),
    .nl_ack    (nl_ack),
    .nl_addr   (nl_addr),
    .fast_cnt  (fast_cnt),
    .slow_cnt  (slow_cnt)
);

// File: tb/test_hetero_dcache.sv
`timescale 1ns/1ps
module test_hetero_dcache;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_apply = 1'b0;
    logic [1:0][1:0]   cfg_mode = '0;
    logic [1:0]        cl_valid = '0;
    logic [1:0]        cl_ready;
    logic [1:0]        cl_we = '0;
    logic [1:0][31:0]  cl_addr = '0;
    logic [1:0][31:0]  cl_wdata = '0;
    logic [1:0]        cl_rvalid;
    logic [1:0][31:0]  cl_rdata;
    logic [1:0]        nl_req;
    logic [1:0]        nl_we;
    logic [1:0][31:0]  nl_addr;
    logic [1:0][31:0]  nl_wdata;
    logic [1:0]        nl_ack = '0;
    logic [1:0][127:0] nl_rline = '0;
    logic [31:0]       fast_cnt, slow_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int nl_cnt [2];
    logic [31:0] nl_last_addr [2];
    logic [31:0] nl_last_data [2];
    logic        nl_last_we [2];

    hetero_dcache i_hetero_dcache (
        .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_mode(cfg_mode),
        .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_we(cl_we), .cl_addr(cl_addr),
        .cl_wdata(cl_wdata), .cl_rvalid(cl_rvalid), .cl_rdata(cl_rdata),
        .nl_req(nl_req), .nl_we(nl_we), .nl_addr(nl_addr), .nl_wdata(nl_wdata),
        .nl_ack(nl_ack), .nl_rline(nl_rline), .fast_cnt(fast_cnt), .slow_cnt(slow_cnt)
    );

    always #5 clk = ~clk;

    // Next-level data: each word holds its own word address xor a constant.
    function automatic logic [31:0] word_pat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [127:0] line_pat(input logic [31:0] a);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) begin
            l[i*32 +: 32] = word_pat({a[31:4], 2'(i), 2'b00});
        end
        return l;
    endfunction

    // Next-level model: acknowledges in the cycle a request appears.
    initial begin
        nl_cnt[0] = 0; nl_cnt[1] = 0;
        forever begin
            @(negedge clk);
            for (int e = 0; e < 2; e++) begin
                if (nl_req[e] && !nl_ack[e]) begin
                    nl_cnt[e]++;
                    nl_last_addr[e] = nl_addr[e];
                    nl_last_data[e] = nl_wdata[e];
                    nl_last_we[e]   = nl_we[e];
                    nl_rline[e]     = line_pat(nl_addr[e]);
                    nl_ack[e]       = 1'b1;
                end else begin
                    nl_ack[e] = 1'b0;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One access from cluster c; lat counts edges from the accepting edge.
    task automatic acc(input int c, input bit we, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
        int w;
        @(negedge clk);
        cl_valid[c] = 1'b1; cl_we[c] = we; cl_addr[c] = a; cl_wdata[c] = wd;
        #1;
        w = 0;
        while (!cl_ready[c] && w < 50) begin
            @(negedge clk); #1; w++;
        end
        @(posedge clk); #1;
        cl_valid[c] = 1'b0;
        lat = -1; rd = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (cl_rvalid[c]) begin
                lat = k - 1; rd = cl_rdata[c];
                break;
            end
        end
    endtask

    task automatic set_modes(input logic [1:0] m0, input logic [1:0] m1);
        @(negedge clk);
        cfg_mode[0] = m0; cfg_mode[1] = m1; cfg_apply = 1'b1;
        @(negedge clk);
        cfg_apply = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 ready c0", 32'(cl_ready[0]), 32'd1);
        check("R10 ready c1", 32'(cl_ready[1]), 32'd1);
        check("R10 rvalid", 32'(cl_rvalid), 32'd0);
        check("R10 fast_cnt", fast_cnt, 32'd0);
        check("R10 slow_cnt", slow_cnt, 32'd0);
    endtask

    task automatic t_fast();
        logic [31:0] rd; int lat; int p0;
        p0 = nl_cnt[0];
        acc(0, 0, 32'h0000_0100, 0, rd, lat);
        check("R2 fast miss latency", 32'(lat), 32'd3);
        check("R2 fast miss data", rd, word_pat(32'h0000_0100));
        check("R1 space 0 uses port 0", 32'(nl_cnt[0] - p0), 32'd1);
        acc(0, 0, 32'h0000_0100, 0, rd, lat);
        check("R2 fast hit latency", 32'(lat), 32'd2);
        check("R2 fast hit data", rd, word_pat(32'h0000_0100));
        check("R2 hit no next-level traffic", 32'(nl_cnt[0] - p0), 32'd1);
        p0 = nl_cnt[1];
        acc(1, 0, 32'h8000_0040, 0, rd, lat);
        check("R1 space 1 uses port 1", 32'(nl_cnt[1] - p0), 32'd1);
        check("R1 space 1 data", rd, word_pat(32'h8000_0040));
    endtask

    task automatic t_write();
        logic [31:0] rd; int lat;
        acc(0, 1, 32'h0000_0104, 32'hDEAD_BEEF, rd, lat);
        check("R4 store latency", 32'(lat), 32'd3);
        check("R4 store addr", nl_last_addr[0], 32'h0000_0104);
        check("R4 store data", nl_last_data[0], 32'hDEAD_BEEF);
        check("R4 store we", 32'(nl_last_we[0]), 32'd1);
        acc(0, 0, 32'h0000_0104, 0, rd, lat);
        check("R4 updated word", rd, 32'hDEAD_BEEF);
        check("R4 updated word hit", 32'(lat), 32'd2);
    endtask

    task automatic t_stall_slow();
        logic [31:0] rd; int lat;
        @(negedge clk);
        cfg_mode[0] = 2'b01; cfg_mode[1] = 2'b10; cfg_apply = 1'b1;
        @(negedge clk); cfg_apply = 1'b0; #1;
        check("R7 ready low pending", 32'(cl_ready[0]), 32'd0);
        @(negedge clk); #1;
        check("R7 ready low stall 1", 32'(cl_ready[0]), 32'd0);
        @(negedge clk); #1;
        check("R7 ready low stall 2", 32'(cl_ready[1]), 32'd0);
        @(negedge clk); #1;
        check("R7 ready back", 32'(cl_ready[0]), 32'd1);
        acc(1, 0, 32'h8000_0040, 0, rd, lat);
        check("R6 R3 kept line slow hit latency", 32'(lat), 32'd4);
        check("R3 slow hit data", rd, word_pat(32'h8000_0040));
        acc(1, 0, 32'h8000_0300, 0, rd, lat);
        check("R3 slow miss latency", 32'(lat), 32'd5);
    endtask

    task automatic t_busy_apply();
        logic [31:0] rd; int lat; int p0, p1;
        fork
            acc(1, 0, 32'h8000_0300, 0, rd, lat);
            begin
                repeat (2) @(negedge clk);
                cfg_mode[0] = 2'b00; cfg_mode[1] = 2'b10; cfg_apply = 1'b1;
                @(negedge clk); cfg_apply = 1'b0;
            end
        join
        check("R7 in-flight keeps slow latency", 32'(lat), 32'd4);
        repeat (5) @(negedge clk);
        p0 = nl_cnt[0]; p1 = nl_cnt[1];
        acc(0, 0, 32'h0000_0104, 0, rd, lat);
        check("R5 redirect latency slow miss", 32'(lat), 32'd5);
        check("R5 redirect uses port 1", 32'(nl_cnt[1] - p1), 32'd1);
        check("R5 redirect leaves port 0", 32'(nl_cnt[0] - p0), 32'd0);
        set_modes(2'b01, 2'b10);
        acc(0, 0, 32'h0000_0104, 0, rd, lat);
        check("R6 invalidated latency", 32'(lat), 32'd3);
        check("R6 invalidated data", rd, word_pat(32'h0000_0104));
    endtask

    task automatic t_both_off();
        logic [31:0] rd; int lat; int p0, p1; logic [31:0] f, s;
        set_modes(2'b00, 2'b11);
        f = fast_cnt; s = slow_cnt;
        p1 = nl_cnt[1];
        acc(1, 0, 32'h8000_0040, 0, rd, lat);
        check("R5 pass-through latency", 32'(lat), 32'd1);
        check("R5 pass-through data", rd, word_pat(32'h8000_0040));
        acc(1, 0, 32'h8000_0040, 0, rd, lat);
        check("R5 pass-through not cached", 32'(nl_cnt[1] - p1), 32'd2);
        p0 = nl_cnt[0];
        acc(0, 0, 32'h0000_0100, 0, rd, lat);
        check("R5 pass-through own port", 32'(nl_cnt[0] - p0), 32'd1);
        check("R9 fast unchanged off", fast_cnt, f);
        check("R9 slow unchanged off", slow_cnt, s);
    endtask

    task automatic t_conflict();
        set_modes(2'b01, 2'b01);
        @(negedge clk);
        cl_valid = 2'b11; cl_we = 2'b00;
        cl_addr[0] = 32'h0000_0200; cl_addr[1] = 32'h0000_0280;
        #1;
        check("R8 cluster 0 wins", 32'(cl_ready[0]), 32'd1);
        check("R8 cluster 1 held", 32'(cl_ready[1]), 32'd0);
        @(posedge clk); #1;
        cl_valid[1] = 1'b0;
        cl_addr[0] = 32'h8000_0000;
        #1;
        check("R8 one outstanding", 32'(cl_ready[0]), 32'd0);
        cl_valid[0] = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 fast count total", fast_cnt, 32'd7);
        check("R9 slow count total", slow_cnt, 32'd4);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast();
        t_write();
        t_stall_slow();
        t_busy_apply();
        t_both_off();
        t_conflict();
        finish_run();
    end
endmodule